// File: doc/BRIEF.md
# DDR Clock-Enable Power-Down Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the clock-enable pin. An idle policy asks for low-power operation through a request input. The sequencer drops CKE only when no read or write access is still in flight. A read is in flight until its postamble has finished, and a write is in flight until write recovery has elapsed. It also follows which banks hold an open row, so it can report whether the device sleeps in precharge power-down (all banks idle) or in active power-down (at least one row open).

A refresh-due indication from the refresh timer blocks entry and forces an exit. During the exit cycle CKE returns high, and a forced-NOP flag tells the command path to put a NOP on the bus. The `cmd_ready` output is held low from the entry cycle through the exit cycle. It rises one cycle after the NOP, so the scheduler cannot issue a command before the device accepts one. The block does not schedule commands. It watches the commands the scheduler issues and gates them.

The state machine has six states. IDLE is the normal running state. ENTER drives CKE low for the sampling edge. PD_PRE and PD_ACT are the two sleep modes. EXIT_NOP raises CKE while forcing a NOP. READY is the first cycle in which commands are allowed again. The transitions are as follows:
- IDLE or READY to ENTER when the request is high, no access is busy, no refresh is due and no command is issued in that cycle. Otherwise READY goes to IDLE and IDLE stays in IDLE.
- ENTER to PD_ACT if any bank is open, otherwise to PD_PRE.
- PD_PRE or PD_ACT to EXIT_NOP when the request drops or a refresh is due.
- EXIT_NOP to READY.

Top module: `ddr_cke_pd_seq`

## Requirements
- R1: The synchronous active-low reset sets the state to IDLE, with `cke`=1, `cmd_ready`=1, `force_nop`=0, `pd_precharge`=0 and `pd_active`=0.
- R2: A read (`cmd_code`=3'd2) issued at clock edge E keeps the device out of power-down. With the request held high, `cke` is first low after edge E+RD_HOLD+1.
- R3: A write (`cmd_code`=3'd3) holds off entry for WR_HOLD cycles in the same way. When read and write windows overlap, entry waits for whichever window ends last.
- R4: A command is issued when `cmd_valid`=1 and `cmd_ready`=1. ACTIVATE (3'd1) marks `cmd_bank` open. PRECHARGE (3'd4) closes `cmd_bank`. PRECHARGE-ALL (3'd5) closes every bank. NOP (3'd0) changes nothing.
- R5: In power-down, `pd_active`=1 if any bank was open at entry and `pd_precharge`=1 otherwise. The two flags are never high together.
- R6: Entry takes one ENTER cycle, with `cke`=0 and `cmd_ready`=0. Entry is refused while `refresh_due`=1 or in a cycle in which a command is issued.
- R7: While in power-down, `pd_req`=0 or `refresh_due`=1 causes the next cycle to be EXIT_NOP, with `cke`=1, `force_nop`=1 and `cmd_ready`=0.
- R8: `cmd_ready` returns to 1 in the cycle after EXIT_NOP, with `force_nop`=0.
- R9: Commands presented while `cmd_ready`=0 have no effect on the bank state or the access windows.
- R10: `cke` stays 0 throughout power-down, and the mode flags are high only while `cke`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Scheduler presents a command |
| cmd_code | input | 3 | Command code (0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA) |
| cmd_bank | input | BANK_W | Target bank of ACT or PRE |
| pd_req | input | 1 | Idle policy asks for power-down |
| refresh_due | input | 1 | Refresh pending: block entry, force exit |
| cke | output | 1 | Clock-enable level to the DRAM |
| force_nop | output | 1 | Command bus must carry a NOP this cycle |
| cmd_ready | output | 1 | Scheduler may issue a command this cycle |
| pd_precharge | output | 1 | In power-down with all banks idle |
| pd_active | output | 1 | In power-down with a row open |

## Verification
The hardest case to reach is a read window and a write window that overlap, where entry must wait for the later end and not the more recent command. The bench issues a write and then a read at every offset inside the write window. For each offset it counts edges until `cke` falls, and compares the count with the larger of the two end times plus the entry latency. Mode classification is checked by sweeping every open-bank pattern, then closing one bank and entering again. That second entry shows that commands offered during sleep were dropped.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

    localparam logic [2:0] OP_NOP  = 3'd0;
    localparam logic [2:0] OP_ACT  = 3'd1;
    localparam logic [2:0] OP_RD   = 3'd2;
    localparam logic [2:0] OP_WR   = 3'd3;
    localparam logic [2:0] OP_PRE  = 3'd4;
    localparam logic [2:0] OP_PREA = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENTER    = 3'd1,
        ST_PD_PRE   = 3'd2,
        ST_PD_ACT   = 3'd3,
        ST_EXIT_NOP = 3'd4,
        ST_READY    = 3'd5
    } pd_state_t;

endpackage

// File: rtl/cke_access_guard.sv
// Counts down the longest outstanding access window (read postamble or
// write recovery); busy while any window is still open.
module cke_access_guard #(
    parameter int RD_HOLD = 3,
    parameter int WR_HOLD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fire,
    input  logic wr_fire,
    output logic busy
);
    localparam int MAX_HOLD = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
    localparam int CNT_W    = $clog2(MAX_HOLD + 1);
    localparam logic [CNT_W-1:0] RD_L = CNT_W'(RD_HOLD);
    localparam logic [CNT_W-1:0] WR_L = CNT_W'(WR_HOLD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        if (rd_fire && (RD_L > cnt_d)) cnt_d = RD_L;
        if (wr_fire && (WR_L > cnt_d)) cnt_d = WR_L;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/cke_bank_tracker.sv
// One open-row bit per bank; reports whether any row is open.
module cke_bank_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_fire,
    input  logic              pre_fire,
    input  logic              prea_fire,
    input  logic [BANK_W-1:0] bank,
    output logic              any_open
);
    logic [NUM_BANKS-1:0] open_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank == BANK_W'(b));
        always_ff @(posedge clk) begin
            if (!rst_n)
                open_q[b] <= 1'b0;
            else if (prea_fire || (pre_fire && hit))
                open_q[b] <= 1'b0;
            else if (act_fire && hit)
                open_q[b] <= 1'b1;
        end
    end

    assign any_open = |open_q;
endmodule

// File: rtl/cke_pd_fsm.sv
module cke_pd_fsm
    import cke_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic refresh_due,
    input  logic busy,
    input  logic cmd_fire,
    input  logic any_open,
    output logic cke,
    output logic force_nop,
    output logic cmd_ready,
    output logic pd_pre,
    output logic pd_act
);
    pd_state_t state_q;
    pd_state_t state_d;
    logic      may_enter;

    assign may_enter = pd_req && !refresh_due && !busy && !cmd_fire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (may_enter) state_d = ST_ENTER;
            ST_ENTER:    state_d = any_open ? ST_PD_ACT : ST_PD_PRE;
            ST_PD_PRE,
            ST_PD_ACT:   if (!pd_req || refresh_due) state_d = ST_EXIT_NOP;
            ST_EXIT_NOP: state_d = ST_READY;
            ST_READY:    state_d = may_enter ? ST_ENTER : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cke       = 1'b1;
        force_nop = 1'b0;
        cmd_ready = 1'b0;
        pd_pre    = 1'b0;
        pd_act    = 1'b0;
        unique case (state_q)
            ST_IDLE,
            ST_READY:    cmd_ready = 1'b1;
            ST_ENTER:    cke = 1'b0;
            ST_PD_PRE: begin
                cke    = 1'b0;
                pd_pre = 1'b1;
            end
            ST_PD_ACT: begin
                cke    = 1'b0;
                pd_act = 1'b1;
            end
            ST_EXIT_NOP: force_nop = 1'b1;
            default:     cmd_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/ddr_cke_pd_seq.sv
module ddr_cke_pd_seq
    import cke_pd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RD_HOLD   = 3,
    parameter int WR_HOLD   = 5,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              pd_req,
    input  logic              refresh_due,
    output logic              cke,
    output logic              force_nop,
    output logic              cmd_ready,
    output logic              pd_precharge,
    output logic              pd_active
);
    logic cmd_fire;
    logic acc_busy;
    logic any_open;

    assign cmd_fire = cmd_valid && cmd_ready;

    cke_access_guard #(
        .RD_HOLD (RD_HOLD),
        .WR_HOLD (WR_HOLD)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (cmd_fire && (cmd_code == OP_RD)),
        .wr_fire (cmd_fire && (cmd_code == OP_WR)),
        .busy    (acc_busy)
    );

    cke_bank_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_fire  (cmd_fire && (cmd_code == OP_ACT)),
        .pre_fire  (cmd_fire && (cmd_code == OP_PRE)),
        .prea_fire (cmd_fire && (cmd_code == OP_PREA)),
        .bank      (cmd_bank),
        .any_open  (any_open)
    );

    cke_pd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (pd_req),
        .refresh_due (refresh_due),
        .busy        (acc_busy),
        .cmd_fire    (cmd_fire),
        .any_open    (any_open),
        .cke         (cke),
        .force_nop   (force_nop),
        .cmd_ready   (cmd_ready),
        .pd_pre      (pd_precharge),
        .pd_act      (pd_active)
    );
endmodule

// File: rtl/cke_pd_checks.sv
module cke_pd_checks (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic force_nop,
    input logic cmd_ready,
    input logic pd_precharge,
    input logic pd_active,
    input logic refresh_due,
    input logic acc_busy
);
    logic seen;
    always_ff @(posedge clk) seen <= rst_n;

    // R2 R3: an open access window never coexists with CKE low
    a_r2_busy_keeps_cke: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        acc_busy |-> cke);

    // R5: mode flags mutually exclusive
    a_r5_one_mode: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !(pd_precharge && pd_active));

    // R10: flags only while CKE low
    a_r10_flags_low_cke: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (pd_precharge || pd_active) |-> !cke);

    // R6: CKE low blocks commands
    a_r6_no_cmd_asleep: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !cke |-> !cmd_ready);

    // R7: every CKE rise carries a forced NOP and withheld commands
    a_r7_exit_nop: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(cke) |-> (force_nop && !cmd_ready));

    // R7: refresh pending during power-down forces exit
    a_r7_refresh_exit: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ((pd_precharge || pd_active) && refresh_due) |=> cke);

    // R8: commands released the cycle after the NOP
    a_r8_ready_after_nop: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        force_nop |=> (cmd_ready && !force_nop));
endmodule

bind ddr_cke_pd_seq cke_pd_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .force_nop    (force_nop),
    .cmd_ready    (cmd_ready),
    .pd_precharge (pd_precharge),
    .pd_active    (pd_active),
    .refresh_due  (refresh_due),
    .acc_busy     (acc_busy)
);

// File: tb/sim_ddr_cke_pd_seq.sv
module sim_ddr_cke_pd_seq;
    localparam int NB = 4;
    localparam int RD = 3;
    localparam int WR = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       pd_req = 1'b0;
    logic       refresh_due = 1'b0;
    logic cke, force_nop, cmd_ready, pd_precharge, pd_active;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddr_cke_pd_seq #(.NUM_BANKS(NB), .RD_HOLD(RD), .WR_HOLD(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .pd_req(pd_req), .refresh_due(refresh_due),
        .cke(cke), .force_nop(force_nop), .cmd_ready(cmd_ready),
        .pd_precharge(pd_precharge), .pd_active(pd_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] b);
        cmd_valid = 1'b1; cmd_code = op; cmd_bank = b;
        tick();
        cmd_valid = 1'b0; cmd_code = 3'd0;
    endtask

    // leave power-down and check the exit sequence
    task automatic leave_pd();
        pd_req = 1'b0;
        tick();
        chk("R7 exit cke", cke, 1);
        chk("R7 exit force_nop", force_nop, 1);
        chk("R7 exit cmd_ready", cmd_ready, 0);
        tick();
        chk("R8 ready after nop", cmd_ready, 1);
        chk("R8 nop released", force_nop, 0);
        tick();
    endtask

    // count edges from a command edge until cke falls
    task automatic wait_low(output int n);
        n = 1;
        while (cke && n < 40) begin
            tick();
            n++;
        end
    endtask

    initial begin
        int n;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cke", cke, 1);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 force_nop", force_nop, 0);
        chk("R1 pd flags", {pd_precharge, pd_active}, 0);

        // R2 read hold-off
        pd_req = 1'b1;
        issue(3'd2, 2'd0);
        wait_low(n);
        chk("R2 read hold-off edges", n, RD + 2);
        tick();
        leave_pd();

        // R3 write hold-off
        pd_req = 1'b1;
        issue(3'd3, 2'd0);
        wait_low(n);
        chk("R3 write hold-off edges", n, WR + 2);
        tick();
        leave_pd();

        // R3 overlap sweep: write at edge 0, read at edge d
        for (int d = 1; d <= WR; d++) begin
            int endt;
            pd_req = 1'b1;
            issue(3'd3, 2'd0);
            for (int k = 1; k < d; k++) tick();
            issue(3'd2, 2'd0);
            wait_low(n);
            endt = (WR > d + RD) ? WR : d + RD;
            chk("R3 overlap hold-off edges", n + d, endt + 2);
            tick();
            leave_pd();
        end

        // R4 R5 bank pattern sweep
        for (int m = 0; m < 16; m++) begin
            int m2;
            pd_req = 1'b0;
            issue(3'd5, 2'd0);
            issue(3'd0, 2'd0);
            for (int b = 0; b < NB; b++)
                if (m[b]) issue(3'd1, 2'(b));
            pd_req = 1'b1;
            tick();
            chk("R6 enter cke low", cke, 0);
            chk("R6 enter cmd_ready", cmd_ready, 0);
            tick();
            chk("R5 active flag", pd_active, (m != 0) ? 1 : 0);
            chk("R5 precharge flag", pd_precharge, (m == 0) ? 1 : 0);
            chk("R10 cke low asleep", cke, 0);
            // R9: ACT to bank 0 while sleeping must be dropped
            cmd_valid = 1'b1; cmd_code = 3'd1; cmd_bank = 2'd0;
            tick();
            cmd_valid = 1'b0;
            leave_pd();
            // R4: close lowest open bank with PRE, re-enter
            m2 = m;
            for (int b = 0; b < NB; b++)
                if (m2 == m && m[b]) m2 = m & ~(1 << b);
            if (m != 0) begin
                for (int b = 0; b < NB; b++)
                    if (m2 != m && ((m ^ m2) >> b) == 1) issue(3'd4, 2'(b));
            end
            pd_req = 1'b1;
            tick(); tick();
            chk("R4 R9 mode after PRE", pd_active, (m2 != 0) ? 1 : 0);
            chk("R4 R9 precharge after PRE", pd_precharge, (m2 == 0) ? 1 : 0);
            leave_pd();
        end

        // R6 R7 refresh behaviour, all banks closed
        pd_req = 1'b0;
        issue(3'd5, 2'd0);
        pd_req = 1'b1;
        tick(); tick();
        chk("R10 asleep", cke, 0);
        refresh_due = 1'b1;
        tick();
        chk("R7 refresh exit cke", cke, 1);
        chk("R7 refresh force_nop", force_nop, 1);
        tick();
        chk("R8 ready after refresh", cmd_ready, 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 refresh blocks entry", cke, 1);
        end
        refresh_due = 1'b0;
        tick();
        chk("R6 re-entry after refresh", cke, 0);
        tick();
        leave_pd();

        // R6 command in same cycle vetoes entry (NOP has no hold window)
        pd_req = 1'b1;
        issue(3'd0, 2'd0);
        chk("R6 command vetoes entry", cke, 1);
        tick();
        chk("R6 entry next cycle", cke, 0);
        tick();
        leave_pd();

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule